// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the slave side of a two-wire bus. The bus has one clock line and one data line, and the master drives the clock. The block samples both lines into a faster system clock. It recognises start and stop conditions and compares the first byte after a start with its own device address.

In a write, it shifts in every following 8-bit word, hands the word to the command layer with a one-cycle strobe, and acknowledges it. In a read, it takes bytes from the command layer and drives them onto the data line through a push-pull output. After each byte it watches the master's acknowledge slot to decide whether to send another byte.

Start and stop detection is disabled in two cases: while the block is driving the line, and while the command layer reports that an internal write is in progress. In the second case the block does not answer its address, so the master can poll for the end of the write. A start or stop that arrives while the block is taking in a byte abandons that byte.

The reset input is asynchronous and active low. It is assumed to be released synchronously to `clk` by the reset logic that feeds this block.

Top module: `twbus_slave_fe`

## Requirements
- R1: While reset is asserted and in the first cycles after it, `sda_oe`, `rx_strobe` and `tx_next` are 0.
- R2: Until a start has been seen, clocked bus traffic is ignored. A matching address byte sent without a preceding start gets no acknowledge, so `sda_oe` stays 0.
- R3: After a start, the first byte is taken as the address byte, most significant bit first, with bits sampled on rising edges of the bus clock. Bits [7:1] form the device address and bit 0 selects the direction, where 1 means read. The block drives the data line low during the ninth clock only when bits [7:1] equal `DEV_ADDR`. For any other address it stays off the line until the next start.
- R4: In a write, each following 8-bit word, MSB first, is presented on `rx_byte` with a single-cycle `rx_strobe`, and the block acknowledges it in the ninth clock.
- R5: In a read, the block captures `tx_byte` with a one-cycle `tx_next` pulse. It drives the byte MSB first and changes bits only while the bus clock is low. It releases the line for the master's acknowledge slot.
- R6: A master acknowledge (data low in the ninth clock) makes the block send the next byte. A non-acknowledge (data high) ends the read and leaves the line released.
- R7: A stop received in the middle of an incoming byte returns the block to idle. No strobe and no acknowledge follow for that byte.
- R8: A start received in the middle of an incoming byte abandons the byte, and the next byte is treated as a new address byte.
- R9: Start and stop conditions that occur while the block is driving the line are ignored, and the byte being sent continues intact.
- R10: While `wr_busy` is 1, start and stop conditions are ignored, so an address byte sent at that time is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Enables the push-pull driver on the data line |
| sda_o | output | 1 | Value driven on the data line when enabled |
| wr_busy | input | 1 | Internal write in progress, from the command layer |
| tx_byte | input | 8 | Next byte to send in a read |
| tx_next | output | 1 | One-cycle pulse when `tx_byte` has been captured |
| rx_byte | output | 8 | Last word received in a write |
| rx_strobe | output | 1 | One-cycle pulse when `rx_byte` is new |

## Verification
Every reaction of the block lands three system clocks after the bus pin edge that causes it:
- two cycles pass through the synchroniser;
- one cycle passes through the state register.

This applies to the acknowledge drive, to each read bit that follows a falling bus clock, and to the release of the line. The bench holds every phase of the bus clock for eight system clocks. It drives pins on falling system-clock edges and samples the data line four clocks into each high phase of the bus clock, which is well after the drive change and before the next fall. `rx_strobe` and `tx_next` are counted on every rising system-clock edge, so a missing or doubled pulse changes the counts that the bench compares.

// File: rtl/twbus_pkg.sv
package twbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_RECV,   // shifting in an address or write word
    ST_ACK,    // driving our acknowledge
    ST_SEND,   // driving read data
    ST_MACK,   // listening to the master acknowledge slot
    ST_MOK     // master acknowledged, wait for clock low
  } tw_state_e;

endpackage

// File: rtl/twbus_sampler.sv
module twbus_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int unsigned LINES = 2;

  logic [LINES-1:0] pins;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign pins = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pins[g]};
      end
      assign synced[g] = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  assign scl_hi    = synced[0];
  assign sda_hi    = synced[1];
  assign scl_rise  = synced[0] & ~prev_q[0];
  assign scl_fall  = ~synced[0] & prev_q[0];
  // Data edges qualify only when the clock was high on both samples.
  assign start_det = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
  assign stop_det  = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];

endmodule

// File: rtl/twbus_ctrl.sv
module twbus_ctrl
  import twbus_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned DEV_ADDR = 'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_hi,
  input  logic              sda_hi,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              wr_busy,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              tx_next,
  output logic              sda_oe,
  output logic              sda_o,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_strobe
);

  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam int unsigned ADDR_W = BYTE_W - 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tw_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shr_q, shr_d;
  logic [BYTE_W-1:0] rxb_q, rxb_d;
  logic              addr_ph_q, addr_ph_d;
  logic              rd_q, rd_d;
  logic              oe_q, oe_d;
  logic              dout_q, dout_d;
  logic              rxs_q, rxs_d;
  logic              txn_q, txn_d;
  logic              det_en;

  // Bus conditions count only when the line is ours to listen to.
  assign det_en = !oe_q && !wr_busy;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    shr_d     = shr_q;
    rxb_d     = rxb_q;
    addr_ph_d = addr_ph_q;
    rd_d      = rd_q;
    oe_d      = oe_q;
    dout_d    = dout_q;
    rxs_d     = 1'b0;
    txn_d     = 1'b0;
    if (det_en && stop_det) begin
      state_d = ST_IDLE;
    end else if (det_en && start_det) begin
      state_d   = ST_RECV;
      cnt_d     = '0;
      addr_ph_d = 1'b1;
    end else begin
      case (state_q)
        ST_RECV: begin
          if (scl_rise && cnt_q != FULL) begin
            shr_d = {shr_q[BYTE_W-2:0], sda_hi};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == FULL) begin
            if (addr_ph_q) begin
              if (shr_q[BYTE_W-1:1] == ADDR_W'(DEV_ADDR)) begin
                state_d = ST_ACK;
                oe_d    = 1'b1;
                dout_d  = 1'b0;
                rd_d    = shr_q[0];
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              rxb_d   = shr_q;
              rxs_d   = 1'b1;
              state_d = ST_ACK;
              oe_d    = 1'b1;
              dout_d  = 1'b0;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            addr_ph_d = 1'b0;
            cnt_d     = '0;
            if (rd_q) begin
              shr_d   = tx_byte;
              txn_d   = 1'b1;
              dout_d  = tx_byte[BYTE_W-1];
              state_d = ST_SEND;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_RECV;
            end
          end
        end
        ST_SEND: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt_q == FULL) begin
              oe_d    = 1'b0;
              state_d = ST_MACK;
            end else begin
              shr_d  = {shr_q[BYTE_W-2:0], 1'b0};
              dout_d = shr_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) state_d = sda_hi ? ST_IDLE : ST_MOK;
        end
        ST_MOK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            shr_d   = tx_byte;
            txn_d   = 1'b1;
            dout_d  = tx_byte[BYTE_W-1];
            oe_d    = 1'b1;
            state_d = ST_SEND;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      shr_q     <= '0;
      rxb_q     <= '0;
      addr_ph_q <= 1'b0;
      rd_q      <= 1'b0;
      oe_q      <= 1'b0;
      dout_q    <= 1'b1;
      rxs_q     <= 1'b0;
      txn_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      shr_q     <= shr_d;
      rxb_q     <= rxb_d;
      addr_ph_q <= addr_ph_d;
      rd_q      <= rd_d;
      oe_q      <= oe_d;
      dout_q    <= dout_d;
      rxs_q     <= rxs_d;
      txn_q     <= txn_d;
    end
  end

  assign sda_oe    = oe_q;
  assign sda_o     = dout_q;
  assign rx_byte   = rxb_q;
  assign rx_strobe = rxs_q;
  assign tx_next   = txn_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> !oe_q);                                   // R2
  AST_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ACK |-> (oe_q && !dout_q));                        // R3
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rxs_q |=> !rxs_q);                                               // R4
  AST_TXNEXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_q |=> !txn_q);                                               // R5
  AST_SEND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && $past(state_q == ST_SEND) && scl_hi && $past(scl_hi))
      |-> $stable(dout_q));                                          // R5
  AST_DRIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |=> state_q != ST_IDLE);                                    // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && state_q == ST_IDLE) |=> state_q == ST_IDLE);         // R10

endmodule

// File: rtl/twbus_slave_fe.sv
module twbus_slave_fe #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned DEV_ADDR    = 'h2A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              sda_o,
  input  logic              wr_busy,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              tx_next,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_strobe
);

  logic scl_hi, sda_hi, scl_rise, scl_fall, start_det, stop_det;

  twbus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_hi    (scl_hi),
    .sda_hi    (sda_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twbus_ctrl #(.BYTE_W(BYTE_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_hi    (scl_hi),
    .sda_hi    (sda_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_busy   (wr_busy),
    .tx_byte   (tx_byte),
    .tx_next   (tx_next),
    .sda_oe    (sda_oe),
    .sda_o     (sda_o),
    .rx_byte   (rx_byte),
    .rx_strobe (rx_strobe)
  );

endmodule

// File: tb/twbus_slave_fe_tb.sv
module twbus_slave_fe_tb;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       wr_busy = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       sda_oe, sda_o, tx_next, rx_strobe;
  logic [7:0] rx_byte;
  logic       sda_line;

  int total = 0;
  int bad = 0;
  int strobes = 0;
  int takes = 0;
  logic [7:0] last_rx = 8'h00;

  always #4 clk = ~clk;

  assign sda_line = m_sda & (sda_oe ? sda_o : 1'b1);

  twbus_slave_fe u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .sda_o(sda_o), .wr_busy(wr_busy), .tx_byte(tx_byte),
    .tx_next(tx_next), .rx_byte(rx_byte), .rx_strobe(rx_strobe)
  );

  always @(posedge clk) begin
    if (rx_strobe) begin
      strobes <= strobes + 1;
      last_rx <= rx_byte;
    end
    if (tx_next) takes <= takes + 1;
  end

  // {address byte, data byte, expected address acknowledge}
  localparam logic [16:0] VECS [6] = '{
    {8'h54, 8'hA5, 1'b1},
    {8'h54, 8'h3C, 1'b1},
    {8'h55, 8'hC3, 1'b1},
    {8'h56, 8'h11, 1'b0},
    {8'h55, 8'h5A, 1'b1},
    {8'h2A, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic read_bit(input logic glitch, output logic b);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q/2);
    b = sda_line;
    if (glitch) begin
      m_sda = 1'b0; wq(Q/2);
      m_sda = 1'b1; wq(Q/2);
    end else begin
      wq(Q/2);
    end
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q/2);
    acked = ~sda_line;
    wq(Q/2);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic read_byte(input logic m_ack, input logic [7:0] nxt, input int glitch_bit,
                           output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      read_bit(i == glitch_bit, b);
      v[i] = b;
    end
    tx_byte = nxt;
    m_sda = ~m_ack; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_scl = 1'b0; wq(Q);
    m_sda = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic       ack;
    logic [7:0] rd;
    int         s0;
    int         t0;
    wq(3);
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 rx_strobe in reset", rx_strobe, 0);
    rst_n = 1'b1;
    wq(4);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 tx_next after reset", tx_next, 0);
    m_scl = 1'b0; wq(Q);

    // R2: our address without any start
    write_byte(8'h54, ack);
    chk("R2 no ack without start", ack, 0);

    // Table walk: R3 address match, R4 write words, R5/R6 single reads
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a;
      logic [7:0] d;
      logic       e;
      {a, d, e} = VECS[k];
      tx_byte = d;
      s0 = strobes;
      bus_start();
      write_byte(a, ack);
      chk($sformatf("R3 vec%0d address ack", k), ack, e);
      if (e && !a[0]) begin
        write_byte(d, ack);
        chk($sformatf("R4 vec%0d word ack", k), ack, 1);
        chk($sformatf("R4 vec%0d strobe count", k), strobes - s0, 1);
        chk($sformatf("R4 vec%0d rx_byte", k), last_rx, d);
      end else if (e) begin
        read_byte(1'b0, d, -1, rd);
        chk($sformatf("R5 vec%0d read data", k), rd, d);
        chk($sformatf("R6 vec%0d released after nak", k), sda_oe, 0);
      end else begin
        chk($sformatf("R3 vec%0d no strobe", k), strobes - s0, 0);
      end
      bus_stop();
    end

    // R5/R6: two-byte read with master acknowledge, then nak
    t0 = takes;
    tx_byte = 8'h81;
    bus_start();
    write_byte(8'h55, ack);
    chk("R5 read address ack", ack, 1);
    read_byte(1'b1, 8'h7E, -1, rd);
    chk("R5 first read byte", rd, 8'h81);
    read_byte(1'b0, 8'h00, -1, rd);
    chk("R6 second byte after master ack", rd, 8'h7E);
    chk("R5 tx_next count", takes - t0, 2);
    read_byte(1'b0, 8'h00, -1, rd);
    chk("R6 line released after nak", rd, 8'hFF);
    bus_stop();

    // R7: stop in the middle of a write word
    s0 = strobes;
    bus_start();
    write_byte(8'h54, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    m_scl = 1'b0; wq(Q);
    write_byte(8'h54, ack);
    chk("R7 no ack after stop", ack, 0);
    chk("R7 no strobe after stop", strobes - s0, 0);

    // R8: start in the middle of a write word
    bus_start();
    write_byte(8'h54, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    write_byte(8'h56, ack);
    chk("R8 foreign address after restart", ack, 0);
    bus_start();
    write_byte(8'h54, ack);
    chk("R8 own address after restart", ack, 1);
    s0 = strobes;
    write_byte(8'h99, ack);
    chk("R8 word after restart", last_rx, 8'h99);
    chk("R8 strobe after restart", strobes - s0, 1);
    bus_stop();

    // R9: fake start and stop while the slave drives a 1
    tx_byte = 8'hA0;
    bus_start();
    write_byte(8'h55, ack);
    read_byte(1'b0, 8'h00, 7, rd);
    chk("R9 byte intact across bus glitch", rd, 8'hA0);
    bus_stop();

    // R10: write in progress hides the address
    wr_busy = 1'b1;
    bus_start();
    write_byte(8'h54, ack);
    chk("R10 no ack while busy", ack, 0);
    bus_stop();
    wr_busy = 1'b0;
    bus_start();
    write_byte(8'h54, ack);
    chk("R10 ack once idle", ack, 1);
    bus_stop();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule